// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit executes a group of six custom multiply-accumulate and multiply-subtract instructions for a RISC-V style integer core. The issue stage presents a 32-bit instruction word with three operand values. The first is the current value of the destination register, which serves as the accumulator. The other two are the source registers. The unit decodes the word, shapes the operands, multiplies them, adds the product to the accumulator or subtracts it, and narrows the result where the variant calls for it.

One cycle after an issue strobe, the unit returns a registered write-back value, a write enable, the destination index and an illegal-instruction flag. A parameter selects a 32-bit or 64-bit data path. An input enables the whole group. The register file, hazard handling and multiplier scheduling belong to the surrounding core.

Top module: `mac_exec_unit`

## Requirements
- R1: The group occupies major opcode 0001011 in bits [6:0] with bits [14:12] equal to 001. The destination index sits in bits [11:7] and is returned on `wb_rd`. The sources sit in [19:15] and [24:20]. The operation is selected by bits [31:27] (funct5) together with bits [26:25] (funct2).
- R2: funct5 00100 with funct2 00 writes acc + a*b. With funct2 01 it writes acc - a*b. Both keep only the low XLEN bits, so overflow wraps.
- R3: funct5 00100 with funct2 10 (add) or 11 (subtract) forms acc ± a*b and writes the low 32 bits sign-extended to XLEN.
- R4: funct5 00101 with funct2 00 (add) or 01 (subtract) first sign-extends bits [15:0] of each source. It then forms acc ± product and writes the low 32 bits sign-extended to XLEN.
- R5: When XLEN is 32, the word variants of R3 raise `illegal` and do not write.
- R6: When `ext_en` is low, all six encodings raise `illegal` and `wb_en` stays low.
- R7: Any other funct5/funct2 pair inside the opcode/funct3 slot, including funct5 00101 with funct2 10 or 11, raises `illegal` and does not write.
- R8: A word outside the opcode/funct3 slot raises neither `illegal` nor `wb_en`.
- R9: A legal operation with destination index 0 keeps `wb_en` low and `illegal` low. `wb_data` still carries the result.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `wb_en` and `illegal` are low whenever `out_valid` is low.
- R11: Whenever `illegal` is high, `wb_data` is zero.
- R12: Synchronous active-high reset clears `out_valid`, `wb_en`, `illegal` and `wb_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| ext_en | input | 1 | Enables the instruction group |
| instr | input | 32 | Instruction word |
| acc_val | input | XLEN | Old value of the destination register |
| src_a | input | XLEN | First source value |
| src_b | input | XLEN | Second source value |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | XLEN | Write-back value |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
Two functions can meet in a single issue: legality screening and the suppression of writes to register 0. For example, a reserved or disabled encoding can target register 0, and a legal one can too. Random streams mix destination index 0 with reserved encodings, with `ext_en` low and with the 32-bit word case. Each result is judged on whether `illegal` is raised and `wb_en` is held low, and on whether `wb_data` is zero or holds the model result. Aliased operands (accumulator equal to a source) and wrap-around values are also driven on the same issues.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam logic [6:0] OPC_CUSTOM = 7'b0001011;
    localparam logic [2:0] F3_MAC     = 3'b001;
    localparam logic [4:0] F5_WIDE    = 5'b00100;
    localparam logic [4:0] F5_HALF    = 5'b00101;

    typedef enum logic [1:0] {
        W_FULL = 2'd0,
        W_WORD = 2'd1,
        W_HALF = 2'd2
    } width_e;

    typedef struct packed {
        logic       in_slot;
        logic       legal;
        logic       sub;
        width_e     width;
        logic [4:0] rd;
    } dec_t;

    function automatic logic [4:0] field_funct5(input logic [31:0] w);
        return w[31:27];
    endfunction

    function automatic logic [1:0] field_funct2(input logic [31:0] w);
        return w[26:25];
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0] instr,
    input  logic        ext_en,
    output dec_t        dec
);
    localparam bit HAS_WORD = (XLEN > 32);

    logic       member;
    logic       word_ok;
    logic       sub_sel;
    width_e     width_sel;

    always_comb begin
        member    = 1'b0;
        word_ok   = 1'b1;
        sub_sel   = 1'b0;
        width_sel = W_FULL;
        unique case ({field_funct5(instr), field_funct2(instr)})
            {F5_WIDE, 2'b00}: begin member = 1'b1; end
            {F5_WIDE, 2'b01}: begin member = 1'b1; sub_sel = 1'b1; end
            {F5_WIDE, 2'b10}: begin member = 1'b1; width_sel = W_WORD; word_ok = HAS_WORD; end
            {F5_WIDE, 2'b11}: begin member = 1'b1; width_sel = W_WORD; word_ok = HAS_WORD; sub_sel = 1'b1; end
            {F5_HALF, 2'b00}: begin member = 1'b1; width_sel = W_HALF; end
            {F5_HALF, 2'b01}: begin member = 1'b1; width_sel = W_HALF; sub_sel = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        dec.in_slot = (instr[6:0] == OPC_CUSTOM) && (instr[14:12] == F3_MAC);
        dec.legal   = dec.in_slot && ext_en && member && word_ok;
        dec.sub     = sub_sel;
        dec.width   = width_sel;
        dec.rd      = instr[11:7];
    end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] acc_val,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result
);
    localparam int HW = 16;
    localparam int WW = 32;

    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] sum;

    always_comb begin
        if (dec.width == W_HALF) begin
            op_a = {{(XLEN-HW){src_a[HW-1]}}, src_a[HW-1:0]};
            op_b = {{(XLEN-HW){src_b[HW-1]}}, src_b[HW-1:0]};
        end else begin
            op_a = src_a;
            op_b = src_b;
        end
        prod = op_a * op_b;
        sum  = dec.sub ? (acc_val - prod) : (acc_val + prod);
    end

    generate
        if (XLEN > WW) begin : g_narrow
            always_comb begin
                if (dec.width != W_FULL)
                    result = {{(XLEN-WW){sum[WW-1]}}, sum[WW-1:0]};
                else
                    result = sum;
            end
        end else begin : g_native
            always_comb result = sum;
        end
    endgenerate

endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
    import mac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            ext_en,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] acc_val,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic            wb_en,
    output logic [4:0]      wb_rd,
    output logic [XLEN-1:0] wb_data,
    output logic            illegal
);
    dec_t            dec;
    logic [XLEN-1:0] result;

    mac_decode #(.XLEN(XLEN)) u_decode (
        .instr  (instr),
        .ext_en (ext_en),
        .dec    (dec)
    );

    mac_datapath #(.XLEN(XLEN)) u_datapath (
        .dec     (dec),
        .acc_val (acc_val),
        .src_a   (src_a),
        .src_b   (src_b),
        .result  (result)
    );

    logic bad;
    assign bad = dec.in_slot && !dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            illegal   <= 1'b0;
            wb_rd     <= '0;
            wb_data   <= '0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && dec.legal && (dec.rd != 5'd0);
            illegal   <= in_valid && bad;
            wb_rd     <= dec.rd;
            wb_data   <= bad ? '0 : result;
        end
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wb_en && !illegal));
    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_rd != 5'd0));
    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (wb_data == '0 && !wb_en));
    a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ext_en) |=> !wb_en);

endmodule

// File: tb/mac_exec_unit_tb.sv
module mac_exec_unit_tb;
    localparam int X64 = 64;
    localparam int X32 = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic ext_en = 1'b1;
    logic [31:0] instr = '0;
    logic [63:0] acc = '0, sa = '0, sb = '0;

    logic ov64, we64, ill64, ov32, we32, ill32;
    logic [4:0] rd64, rd32;
    logic [63:0] d64;
    logic [31:0] d32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mac_exec_unit #(.XLEN(X64)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .instr(instr),
        .acc_val(acc), .src_a(sa), .src_b(sb),
        .out_valid(ov64), .wb_en(we64), .wb_rd(rd64), .wb_data(d64), .illegal(ill64));

    mac_exec_unit #(.XLEN(X32)) u_dut32 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .instr(instr),
        .acc_val(acc[31:0]), .src_a(sa[31:0]), .src_b(sb[31:0]),
        .out_valid(ov32), .wb_en(we32), .wb_rd(rd32), .wb_data(d32), .illegal(ill32));

    typedef struct packed {
        logic        ill;
        logic        we;
        logic        legal;
        logic [63:0] data;
    } exp_t;

    function automatic logic [31:0] enc(logic [4:0] f5, logic [1:0] f2,
                                        logic [4:0] rd, logic [4:0] r1, logic [4:0] r2);
        return {f5, f2, r2, r1, 3'b001, rd, 7'b0001011};
    endfunction

    function automatic exp_t model(logic [31:0] w, logic [63:0] c, logic [63:0] a,
                                   logic [63:0] b, bit is64, bit en);
        exp_t e;
        bit slot, mem, sub, narrow, half, word;
        logic [63:0] oa, ob, s;
        slot = (w[6:0] == 7'b0001011) && (w[14:12] == 3'b001);
        mem = 0; sub = w[25]; half = 0; word = 0;
        if (w[31:27] == 5'b00100) begin mem = 1; word = w[26]; end
        if (w[31:27] == 5'b00101 && w[26] == 1'b0) begin mem = 1; half = 1; end
        narrow = half || word;
        oa = half ? {{48{a[15]}}, a[15:0]} : a;
        ob = half ? {{48{b[15]}}, b[15:0]} : b;
        s = sub ? c - oa * ob : c + oa * ob;
        if (narrow) s = {{32{s[31]}}, s[31:0]};
        e.legal = slot && en && mem && !(word && !is64);
        e.ill   = slot && !e.legal;
        e.we    = e.legal && (w[11:7] != 5'd0);
        e.data  = e.ill ? 64'd0 : s;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [63:0] c, logic [63:0] a, logic [63:0] b,
                         bit en, string tag);
        exp_t e64, e32;
        @(negedge clk);
        instr = w; acc = c; sa = a; sb = b; ext_en = en; in_valid = 1'b1;
        e64 = model(w, c, a, b, 1'b1, en);
        e32 = model(w, c, a, b, 1'b0, en);
        @(negedge clk);
        in_valid = 1'b0;
        chk(ov64 && ov32, {tag, " R10 valid"}, {ov64, ov32}, 2'b11);
        chk(ill64 == e64.ill, {tag, " illegal64"}, ill64, e64.ill);
        chk(we64 == e64.we, {tag, " wb_en64"}, we64, e64.we);
        chk(rd64 == w[11:7], {tag, " R1 wb_rd"}, rd64, w[11:7]);
        if (e64.ill || e64.legal) chk(d64 == e64.data, {tag, " data64"}, d64, e64.data);
        chk(ill32 == e32.ill, {tag, " illegal32"}, ill32, e32.ill);
        chk(we32 == e32.we, {tag, " wb_en32"}, we32, e32.we);
        if (e32.ill || e32.legal) chk(d32 == e32.data[31:0], {tag, " data32"}, d32, e32.data[31:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd7713);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(!ov64 && !we64 && !ill64 && d64 == 0, "R12 reset64", {ov64, we64, ill64}, 0);
        chk(!ov32 && !we32 && !ill32 && d32 == 0, "R12 reset32", {ov32, we32, ill32}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ov64 && !ov32, "R10 idle after reset", ov64, 0);

        // R2: wrap-around and subtract
        issue(enc(5'b00100, 2'b00, 5'd3, 5'd4, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 1, "R2 add wrap");
        issue(enc(5'b00100, 2'b01, 5'd3, 5'd4, 5'd5), 64'd0, 64'd3, 64'd5, 1, "R2 sub wrap");
        issue(enc(5'b00100, 2'b00, 5'd7, 5'd7, 5'd2), 64'h1234, 64'h1234, 64'h10, 1, "R2 rd alias rs1");
        // R3: word variants with high bits
        issue(enc(5'b00100, 2'b10, 5'd9, 5'd1, 5'd2), 64'hDEAD_0000_7FFF_FFFF, 64'd1, 64'd1, 1, "R3 word add");
        issue(enc(5'b00100, 2'b11, 5'd9, 5'd9, 5'd9), 64'h1_0000_0000, 64'h1_0000_0000, 64'h1_0000_0000, 1, "R3 word sub alias");
        // R4: halfword negatives
        issue(enc(5'b00101, 2'b00, 5'd6, 5'd1, 5'd2), 64'd0, 64'hFFFF_8000, 64'h0000_8000, 1, "R4 half add");
        issue(enc(5'b00101, 2'b01, 5'd6, 5'd1, 5'd2), 64'd5, 64'h7777_FFFF, 64'h0002, 1, "R4 half sub");
        // R7: reserved encodings
        issue(enc(5'b00101, 2'b10, 5'd6, 5'd1, 5'd2), 64'd5, 64'd3, 64'd3, 1, "R7 half f2=10");
        issue(enc(5'b00101, 2'b11, 5'd0, 5'd1, 5'd2), 64'd5, 64'd3, 64'd3, 1, "R7 half f2=11 rd0");
        issue(enc(5'b10100, 2'b00, 5'd6, 5'd1, 5'd2), 64'd5, 64'd3, 64'd3, 1, "R7 funct5");
        // R8: outside slot
        issue(enc(5'b00100, 2'b00, 5'd6, 5'd1, 5'd2) ^ 32'h0000_1000, 64'd5, 64'd3, 64'd3, 1, "R8 funct3");
        issue(enc(5'b00100, 2'b00, 5'd6, 5'd1, 5'd2) ^ 32'h0000_0020, 64'd5, 64'd3, 64'd3, 1, "R8 opcode");
        // R9: rd = 0
        issue(enc(5'b00100, 2'b00, 5'd0, 5'd1, 5'd2), 64'd5, 64'd3, 64'd3, 1, "R9 rd zero");
        // R6 and R5: disabled group, word ops illegal in 32-bit
        for (int k = 0; k < 6; k++) begin
            logic [4:0] f5;
            logic [1:0] f2;
            f5 = (k < 4) ? 5'b00100 : 5'b00101;
            f2 = (k < 4) ? 2'(k) : 2'(k - 4);
            issue(enc(f5, f2, 5'd12, 5'd1, 5'd2), 64'd9, 64'd4, 64'd4, 0, "R6 ext off");
            issue(enc(f5, f2, 5'd12, 5'd1, 5'd2), 64'd9, 64'd4, 64'd4, 1, "R5 R3 R4 set");
        end
        @(negedge clk);
        chk(!ov64 && !we64 && !ill64, "R10 quiet gap", {ov64, we64, ill64}, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0] f5;
            logic [1:0] f2;
            logic [63:0] c, a, b;
            int sel;
            sel = $urandom_range(0, 9);
            f5 = (sel < 5) ? 5'b00100 : ((sel < 8) ? 5'b00101 : 5'($urandom));
            f2 = 2'($urandom);
            c = {$urandom, $urandom};
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
            if ($urandom_range(0, 4) == 0) c = a;
            issue(enc(f5, f2, 5'($urandom_range(0, 3) == 0 ? 0 : $urandom), 5'($urandom), 5'($urandom)),
                  c, a, b, ($urandom_range(0, 7) != 0), "R2 R3 R4 R7 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule